// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block holds the status byte of a serial NOR flash and decides when that byte may be rewritten. It sits behind a byte-level SPI slave front end. The front end reports the start and the end of each chip-select window as single-cycle pulses. It delivers each received byte on a valid/ready stream. The block decodes three commands from the first byte of a window: set write enable (0x06), write status (0x01) and read status (0x05).

A status write is committed only when the window closes directly after its single data byte. It also needs the write-enable latch to be set, and the hardware lock to be off. A commit updates the protection bits and starts a self-timed busy period of `TW_CYCLES` clocks. At the end of that period the write-enable latch clears. The hardware lock is on while the status-write-disable bit is set and the active-low write-protect pin is low. Read status offers the status byte on an outgoing valid/ready stream. A new snapshot is taken when the command byte is taken and again after each accepted byte. Reading works during the busy period, so software can poll it.

Back-pressure rules: the block never stalls the receive stream, so `rx_ready` is always 1 and a byte moves on every cycle that `rx_valid` is high. On the transmit side, `tx_data` holds its value while `tx_valid` is high and `tx_ready` is low. It changes only after a transfer (`tx_valid && tx_ready`) or when the window closes.

Top module: `spi_sr_guard`

## Requirements
- R1: After reset, `status_o` is 0x00, `hw_locked_o` is 0, `tx_valid` is 0 and `rx_ready` is 1.
- R2: A window holding only the byte 0x06 sets the write-enable latch (status bit 1) when it closes. The busy flag can rise only while that latch is set.
- R3: The status byte is laid out as: bit 7 status-write-disable, bits 6 and 5 always 0, bits 4..2 block-protect 2..0, bit 1 write-enable latch, bit 0 busy. An accepted write copies data bits 7 and 4..2 and nothing else.
- R4: An accepted write sets status bit 0 for exactly `TW_CYCLES` clocks after the closing edge. The write-enable latch clears in the same cycle that bit 0 falls.
- R5: A write-status window closed while the write-enable latch is clear changes nothing and starts no busy period.
- R6: A write-status window that closes before its data byte, or after more than one data byte, changes nothing and leaves the write-enable latch as it was.
- R7: `hw_locked_o` equals status bit 7 AND NOT `wp_n`. While it is 1, a status write is rejected even with the write-enable latch set, and the latch is kept.
- R8: A write is accepted with the latch set when bit 7 is 0 (at either `wp_n` level), or when bit 7 is 1 and `wp_n` is high.
- R9: After the byte 0x05, `tx_valid` is 1 until the window closes. `tx_data` is the status captured when the command byte or the last transferred byte was taken, and it stays stable while no transfer occurs. This works during the busy period.
- R10: While bit 0 is 1, a write-status window is ignored and neither restarts nor changes the busy period.
- R11: Bytes outside a window, unknown opcodes and a set-write-enable window with extra bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_start | input | 1 | Pulse: chip select went active |
| sel_end | input | 1 | Pulse: chip select went inactive |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Always 1; block never stalls input |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Status byte offered to the shifter |
| tx_ready | input | 1 | Shifter takes the offered byte |
| tx_data | output | 8 | Status snapshot to send |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Live status byte |
| hw_locked_o | output | 1 | Hardware protected mode indicator |

## Verification
The hardest case to reach is a second write-status window that closes inside the busy period of a first one. Only correct timing shows whether the timer was restarted or the data leaked through. The stimulus commits one write and then sends a complete second write within `TW_CYCLES`, before checking the final status well after the first period should end. A similar timed sequence opens a read window during busy. It holds `tx_ready` low past the end of the period and then pulses it, so the snapshot must first stay stale and then pick up the cleared latch.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam logic [7:0] OP_SET_WE = 8'h06;
  localparam logic [7:0] OP_WR_ST  = 8'h01;
  localparam logic [7:0] OP_RD_ST  = 8'h05;

  localparam int PROT_BITS = 3;

  typedef enum logic [2:0] {
    CMD_OFF,
    CMD_OPCODE,
    CMD_WE_SEEN,
    CMD_WAIT_DATA,
    CMD_ARMED,
    CMD_READ,
    CMD_SKIP
  } cmd_state_t;
endpackage

// File: rtl/spi_sr_decode.sv
module spi_sr_decode
  import spi_sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_start,
  input  logic       sel_end,
  input  logic       rx_fire,
  input  logic [7:0] rx_byte,
  input  logic       busy,
  output logic       we_req,
  output logic       commit_req,
  output logic       rd_load,
  output logic       read_act,
  output logic [7:0] wr_byte
);
  cmd_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CMD_OFF;
      wr_byte <= '0;
    end else if (sel_end) begin
      st <= CMD_OFF;
    end else if (sel_start) begin
      st <= CMD_OPCODE;
    end else if (rx_fire) begin
      case (st)
        CMD_OPCODE: begin
          if (rx_byte == OP_RD_ST) begin
            st <= CMD_READ;
          end else if (busy) begin
            st <= CMD_SKIP;
          end else begin
            case (rx_byte)
              OP_SET_WE: st <= CMD_WE_SEEN;
              OP_WR_ST:  st <= CMD_WAIT_DATA;
              default:   st <= CMD_SKIP;
            endcase
          end
        end
        CMD_WE_SEEN: st <= CMD_SKIP;
        CMD_WAIT_DATA: begin
          wr_byte <= rx_byte;
          st      <= CMD_ARMED;
        end
        CMD_ARMED: st <= CMD_SKIP;
        default:   st <= st;
      endcase
    end
  end

  assign we_req     = sel_end && (st == CMD_WE_SEEN);
  assign commit_req = sel_end && (st == CMD_ARMED);
  assign rd_load    = rx_fire && !sel_end && !sel_start &&
                      (st == CMD_OPCODE) && (rx_byte == OP_RD_ST);
  assign read_act   = (st == CMD_READ);
endmodule

// File: rtl/spi_sr_timer.sv
module spi_sr_timer #(
  parameter int TW_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TW_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(TW_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);
  assign done = (remain == CW'(1));
endmodule

// File: rtl/spi_sr_regs.sv
module spi_sr_regs
  import spi_sr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_req,
  input  logic                 commit_req,
  input  logic [7:0]           wr_byte,
  input  logic                 wp_n,
  input  logic                 busy,
  input  logic                 done,
  output logic                 start,
  output logic                 srwd,
  output logic [PROT_BITS-1:0] prot,
  output logic                 wel,
  output logic                 hw_lock
);
  localparam int PROT_LSB = 2;

  logic grant;

  assign hw_lock = srwd && !wp_n;
  assign grant   = commit_req && wel && !hw_lock && !busy;
  assign start   = grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd <= 1'b0;
      prot <= '0;
    end else if (grant) begin
      srwd <= wr_byte[7];
      prot <= wr_byte[PROT_LSB +: PROT_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (done) begin
      wel <= 1'b0;
    end else if (we_req && !busy) begin
      wel <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard
  import spi_sr_pkg::*;
#(
  parameter int TW_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_start,
  input  logic       sel_end,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  input  logic       wp_n,
  output logic [7:0] status_o,
  output logic       hw_locked_o
);
  logic                 rx_fire;
  logic                 we_req, commit_req, rd_load, read_act;
  logic [7:0]           wr_byte;
  logic                 busy, done, start;
  logic                 srwd, wel, hw_lock;
  logic [PROT_BITS-1:0] prot;
  logic [7:0]           snap;

  assign rx_ready = 1'b1;
  assign rx_fire  = rx_valid;

  spi_sr_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_start (sel_start),
    .sel_end   (sel_end),
    .rx_fire   (rx_fire),
    .rx_byte   (rx_data),
    .busy      (busy),
    .we_req    (we_req),
    .commit_req(commit_req),
    .rd_load   (rd_load),
    .read_act  (read_act),
    .wr_byte   (wr_byte)
  );

  spi_sr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_req    (we_req),
    .commit_req(commit_req),
    .wr_byte   (wr_byte),
    .wp_n      (wp_n),
    .busy      (busy),
    .done      (done),
    .start     (start),
    .srwd      (srwd),
    .prot      (prot),
    .wel       (wel),
    .hw_lock   (hw_lock)
  );

  spi_sr_timer #(.TW_CYCLES(TW_CYCLES)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done)
  );

  assign status_o    = {srwd, 2'b00, prot, wel, busy};
  assign hw_locked_o = hw_lock;
  assign tx_valid    = read_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
    end else if (rd_load || (read_act && tx_ready)) begin
      snap <= status_o;
    end
  end

  assign tx_data = snap;
endmodule

// File: rtl/spi_sr_guard_chk.sv
module spi_sr_guard_chk #(
  parameter int TW_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status_o,
  input logic       hw_locked_o,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else if (status_o[0]) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  // R3
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> busy_run == TW_CYCLES);

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> !status_o[1]);

  // R2
  busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(status_o[1]));

  // R7
  hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_locked_o |=> status_o[7:2] == $past(status_o[7:2]));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || $stable(tx_data)));

  // R10
  busy_no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |=> !$rose(status_o[1]));
endmodule

bind spi_sr_guard spi_sr_guard_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status_o   (status_o),
  .hw_locked_o(hw_locked_o),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data)
);

// File: tb/spi_sr_guard_test.sv
module spi_sr_guard_test;
  localparam int TW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_start = 1'b0, sel_end = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_ready = 1'b0;
  logic       wp_n = 1'b1;
  logic       rx_ready, tx_valid, hw_locked_o;
  logic [7:0] tx_data, status_o;

  typedef struct {
    logic [7:0] st;
    logic       lock;
    logic       txv;
    logic [7:0] txd;
    string      tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  spi_sr_guard #(.TW_CYCLES(TW)) uut (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_end(sel_end),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .wp_n(wp_n), .status_o(status_o), .hw_locked_o(hw_locked_o)
  );

  // monitor: pops one expected item per cycle, between edges
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (status_o !== it.st || hw_locked_o !== it.lock || tx_valid !== it.txv ||
          rx_ready !== 1'b1 || (it.txv && tx_data !== it.txd)) begin
        bad++;
        $display("FAIL %s: status=%h lock=%b txv=%b txd=%h rxr=%b, expected status=%h lock=%b txv=%b txd=%h rxr=1",
                 it.tag, status_o, hw_locked_o, tx_valid, tx_data, rx_ready,
                 it.st, it.lock, it.txv, it.txd);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [7:0] st, input logic lock, input logic txv,
                     input logic [7:0] txd, input string tag);
    item_t it;
    it.st = st; it.lock = lock; it.txv = txv; it.txd = txd; it.tag = tag;
    sb.push_back(it);
    tick();
  endtask

  task automatic put(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; tick(); rx_valid = 1'b0;
  endtask

  task automatic open_w();
    sel_start = 1'b1; tick(); sel_start = 1'b0;
  endtask

  task automatic close_w();
    sel_end = 1'b1; tick(); sel_end = 1'b0;
  endtask

  task automatic set_we();
    open_w(); put(8'h06); close_w();
  endtask

  task automatic wr_st(input logic [7:0] d);
    open_w(); put(8'h01); put(d); close_w();
  endtask

  // called right after close_w of an accepted write
  task automatic ride_busy(input logic [7:0] mid, input logic [7:0] fin,
                           input logic lock, input string tag);
    chk(mid, lock, 1'b0, 8'h00, tag);
    repeat (TW - 2) tick();
    chk(mid, lock, 1'b0, 8'h00, tag);
    chk(fin, lock, 1'b0, 8'h00, tag);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(8'h00, 1'b0, 1'b0, 8'h00, "R1 reset");

    wr_st(8'h9C);
    chk(8'h00, 1'b0, 1'b0, 8'h00, "R5 no latch");

    set_we();
    chk(8'h02, 1'b0, 1'b0, 8'h00, "R2 set latch");

    open_w(); put(8'h01); close_w();
    chk(8'h02, 1'b0, 1'b0, 8'h00, "R6 early close");
    open_w(); put(8'h01); put(8'h9C); put(8'h00); close_w();
    chk(8'h02, 1'b0, 1'b0, 8'h00, "R6 late close");

    wr_st(8'hFF);
    ride_busy(8'h9F, 8'h9C, 1'b0, "R3 R4 write ff");

    wp_n = 1'b0; tick();
    chk(8'h9C, 1'b1, 1'b0, 8'h00, "R7 lock on");
    set_we();
    chk(8'h9E, 1'b1, 1'b0, 8'h00, "R7 latch set");
    wr_st(8'h00);
    chk(8'h9E, 1'b1, 1'b0, 8'h00, "R7 rejected");

    wp_n = 1'b1; tick();
    wr_st(8'h00);
    ride_busy(8'h03, 8'h00, 1'b0, "R8 pin high");

    wp_n = 1'b0; tick();
    set_we();
    wr_st(8'h6C);
    ride_busy(8'h0F, 8'h0C, 1'b0, "R8 bit7 clear pin low");
    wp_n = 1'b1; tick();

    open_w(); put(8'h05);
    chk(8'h0C, 1'b0, 1'b1, 8'h0C, "R9 read");
    put(8'h06);
    chk(8'h0C, 1'b0, 1'b1, 8'h0C, "R9 extra byte");
    close_w();
    chk(8'h0C, 1'b0, 1'b0, 8'h00, "R9 closed");

    set_we();
    wr_st(8'h10);
    open_w(); put(8'h05);
    chk(8'h13, 1'b0, 1'b1, 8'h13, "R9 poll busy");
    repeat (TW + 2) tick();
    chk(8'h10, 1'b0, 1'b1, 8'h13, "R9 snapshot held");
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    chk(8'h10, 1'b0, 1'b1, 8'h10, "R9 refreshed");
    close_w();

    set_we();
    wr_st(8'h84);
    chk(8'h87, 1'b0, 1'b0, 8'h00, "R10 busy");
    wr_st(8'h08);
    repeat (TW - 5) tick();
    chk(8'h84, 1'b0, 1'b0, 8'h00, "R10 period not restarted");
    repeat (TW) tick();
    chk(8'h84, 1'b0, 1'b0, 8'h00, "R10 ignored");

    put(8'h06); put(8'h00);
    chk(8'h84, 1'b0, 1'b0, 8'h00, "R11 outside window");
    open_w(); put(8'hAB); close_w();
    chk(8'h84, 1'b0, 1'b0, 8'h00, "R11 unknown opcode");
    open_w(); put(8'h06); put(8'h00); close_w();
    chk(8'h84, 1'b0, 1'b0, 8'h00, "R11 set-we extra byte");

    tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule